// File: doc/BRIEF.md
# Queued Move Command Sequencer

This block runs the move commands of one quadrature channel in the order they were written. A host writes a move length into a two-entry count queue and, optionally, a 32-bit control word into a parallel two-entry control queue. When the channel is enabled and no move is in progress, the sequencer takes the oldest length as the current move and takes the oldest control word with it. Each step strobe from the pulse generator then lowers the current move by one until it reaches zero. If no new control word is waiting, the previous one stays in force, so a run of moves at the same rate needs only count writes.

The sequencer is a two-state machine. In state `ST_IDLE` the current count is zero and a load may happen. In state `ST_RUN` the count is non-zero and step strobes are honoured. Transition `IDLE_TO_RUN` fires on a load of a non-zero length. Transition `RUN_TO_IDLE` fires on a step while the count is one. A load of a zero length keeps the machine in `ST_IDLE`.

The block drives the auxiliary output from the current control word. It flags queue space, queue empty, move complete and idle. Two sticky event flags, one for loads and one for completions, combine into an interrupt request.

Top module: `mvq_sequencer`

## Requirements
- R1: The count queue holds two entries. `slots_avail` is low exactly when both entries are filled. A count write while the queue is full is dropped, and the queued values are left unchanged.
- R2: A load happens only when all of the following hold: the current count is zero, `enable` is high, the count queue is not empty and `queue_clr` is low. On a load, the oldest queued length becomes `cur_count` on the next clock edge. While `enable` is low, queued lengths stay in the queue.
- R3: In `ST_RUN`, each cycle with `step` high lowers `cur_count` by one. A step while `cur_count` is zero has no effect.
- R4: The control queue holds two entries and is popped on every load. If the control queue is empty at a load, `cur_ctrl` keeps its previous value. The control word layout is: bits 23..0 count width, bit 24 direction, bit 25 aux level, bits 31..26 marker width.
- R5: `aux_out` equals bit 25 of `cur_ctrl` and changes only on a load.
- R6: `queue_empty` is high when no length is queued. `move_done` is high when `cur_count` is zero and the count queue is empty. `idle` is high exactly when `move_done` and `queue_empty` are both high.
- R7: `ld_occur` is set on the clock edge of each load while `ld_det_en` is high. It stays set until it is cleared by `occ_clr` bit 0. A set in the same cycle as a clear wins.
- R8: `mc_occur` is set one cycle after each rising edge of `move_done` while `mc_det_en` is high. It is cleared by `occ_clr` bit 1, and a set in the same cycle wins. The first high level of `move_done` after reset is not counted as a rising edge.
- R9: `irq` is high exactly when `ld_occur` is high with `ld_irq_en` high, or `mc_occur` is high with `mc_irq_en` high.
- R10: A pulse on `queue_clr` empties both queues. No write is accepted and no load happens in that cycle. `cur_count` and `cur_ctrl` are untouched.
- R11: After reset, the following are zero: `cur_count`, `cur_ctrl`, `aux_out`, both occur flags and `irq`. After reset, `slots_avail`, `queue_empty`, `move_done` and `idle` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel enable; allows loads |
| cnt_wr | input | 1 | Write strobe for the count queue |
| cnt_wdata | input | 24 | Move length to queue |
| ctl_wr | input | 1 | Write strobe for the control queue |
| ctl_wdata | input | 32 | Control word to queue |
| step | input | 1 | Step strobe; lowers the current count by one |
| queue_clr | input | 1 | Empties both queues |
| ld_det_en | input | 1 | Enables the load event detector |
| mc_det_en | input | 1 | Enables the move-complete event detector |
| ld_irq_en | input | 1 | Lets `ld_occur` drive `irq` |
| mc_irq_en | input | 1 | Lets `mc_occur` drive `irq` |
| occ_clr | input | 2 | Write-one-to-clear: bit 0 clears `ld_occur`, bit 1 clears `mc_occur` |
| cur_count | output | 24 | Remaining steps of the current move |
| cur_ctrl | output | 32 | Control word in force |
| aux_out | output | 1 | Auxiliary level of the current command |
| slots_avail | output | 1 | Count queue has a free entry |
| queue_empty | output | 1 | No length is queued |
| move_done | output | 1 | Current count is zero and the queue is empty |
| idle | output | 1 | Channel idle |
| ld_occur | output | 1 | Sticky load event |
| mc_occur | output | 1 | Sticky move-complete event |
| irq | output | 1 | Interrupt request |

## Verification
Random traffic uses short lengths (0 to 4) and step strobes on about half the cycles. This makes moves end, reload back to back, and sometimes load a zero length, which separates the `ST_IDLE` hold from a real run. Writes arrive at random rates, so the queues fill, overflow and drain. This shows dropped writes and control-word reuse apart from normal pops. A directed phase holds `enable` low while three lengths are written, so a full-queue drop is tested without a competing pop. A clear pulse with data present then shows that the queues are emptied while the current move is left alone. Random clear strobes and event-enable toggles test the set-wins rule and the edge detection of `move_done`.

// File: rtl/mvq_pkg.sv
package mvq_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    localparam int unsigned DEF_AUX_POS = 25;
endpackage

// File: rtl/mvq_fifo.sv
module mvq_fifo #(
    parameter int unsigned W     = 24,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rptr, wptr;
    logic [CW-1:0] fill;
    logic          push_ok, pop_ok;

    assign empty   = (fill == '0);
    assign full    = (fill == CW'(DEPTH));
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr <= '0;
            wptr <= '0;
            fill <= '0;
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
        end else if (clr) begin
            rptr <= '0;
            wptr <= '0;
            fill <= '0;
        end else begin
            if (push_ok) begin
                mem[wptr] <= wdata;
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (pop_ok)
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // R1: a write into a full queue neither adds an entry nor disturbs the head
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (full && $stable(rdata)));

    // R10: a clear leaves the queue empty
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);
endmodule

// File: rtl/mvq_event.sv
module mvq_event (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic occ
);
    always_ff @(posedge clk) begin
        if (!rst_n)   occ <= 1'b0;
        else if (set) occ <= 1'b1;
        else if (clr) occ <= 1'b0;
    end

    // R7 and R8: the flag is sticky until a clear strobe
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (occ && !clr) |=> occ);

    // R7 and R8: a set is never lost to a simultaneous clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> occ);
endmodule

// File: rtl/mvq_sequencer.sv
module mvq_sequencer #(
    parameter int unsigned CNT_W   = 24,
    parameter int unsigned CTL_W   = 32,
    parameter int unsigned DEPTH   = 2,
    parameter int unsigned AUX_POS = mvq_pkg::DEF_AUX_POS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             step,
    input  logic             queue_clr,
    input  logic             ld_det_en,
    input  logic             mc_det_en,
    input  logic             ld_irq_en,
    input  logic             mc_irq_en,
    input  logic [1:0]       occ_clr,
    output logic [CNT_W-1:0] cur_count,
    output logic [CTL_W-1:0] cur_ctrl,
    output logic             aux_out,
    output logic             slots_avail,
    output logic             queue_empty,
    output logic             move_done,
    output logic             idle,
    output logic             ld_occur,
    output logic             mc_occur,
    output logic             irq
);
    import mvq_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cq_head;
    logic [CTL_W-1:0] kq_head;
    logic             cq_empty, cq_full, kq_empty, kq_full;
    logic             load, md_q, mc_rise;

    mvq_fifo #(.W(CNT_W), .DEPTH(DEPTH)) u_cnt_q (
        .clk(clk), .rst_n(rst_n), .clr(queue_clr),
        .push(cnt_wr), .pop(load), .wdata(cnt_wdata),
        .rdata(cq_head), .empty(cq_empty), .full(cq_full)
    );

    mvq_fifo #(.W(CTL_W), .DEPTH(DEPTH)) u_ctl_q (
        .clk(clk), .rst_n(rst_n), .clr(queue_clr),
        .push(ctl_wr), .pop(load), .wdata(ctl_wdata),
        .rdata(kq_head), .empty(kq_empty), .full(kq_full)
    );

    assign load = (state_q == ST_IDLE) && enable && !cq_empty && !queue_clr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load && cq_head != '0)      state_d = ST_RUN;
            ST_RUN:  if (step && cur_count == ONE)   state_d = ST_IDLE;
        endcase
    end

    // datapath registers: current move and control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_count <= '0;
            cur_ctrl  <= '0;
            md_q      <= 1'b1;
        end else begin
            md_q <= move_done;
            if (load) begin
                cur_count <= cq_head;
                if (!kq_empty) cur_ctrl <= kq_head;
            end else if (state_q == ST_RUN && step) begin
                cur_count <= cur_count - ONE;
            end
        end
    end

    // status outputs
    always_comb begin
        slots_avail = !cq_full;
        queue_empty = cq_empty;
        move_done   = (state_q == ST_IDLE) && cq_empty;
        idle        = move_done && queue_empty;
        aux_out     = cur_ctrl[AUX_POS];
        mc_rise     = move_done && !md_q;
        irq         = (ld_occur && ld_irq_en) || (mc_occur && mc_irq_en);
    end

    mvq_event u_ld_evt (
        .clk(clk), .rst_n(rst_n), .set(load && ld_det_en),
        .clr(occ_clr[0]), .occ(ld_occur)
    );

    mvq_event u_mc_evt (
        .clk(clk), .rst_n(rst_n), .set(mc_rise && mc_det_en),
        .clr(occ_clr[1]), .occ(mc_occur)
    );

    // R2: a running move is never replaced; the count only changes by stepping
    a_r2_no_reload_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !step) |=> $stable(cur_count));

    // R3: each step in a run lowers the count by exactly one
    a_r3_step_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && step) |=> (cur_count == $past(cur_count) - ONE));

    // R3: the idle state always holds a zero count
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cur_count == '0));

    // R5: the aux level moves only with a load
    a_r5_aux_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(aux_out));

    // R6: completion implies an empty queue
    a_r6_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
        move_done |-> queue_empty);

    // R9: an enabled pending event always raises the request
    a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_occur && ld_irq_en) |-> irq);
endmodule

// File: tb/mvq_sequencer_test.sv
module mvq_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 0, cnt_wr = 0, ctl_wr = 0, step = 0, queue_clr = 0;
    logic [23:0] cnt_wdata = '0;
    logic [31:0] ctl_wdata = '0;
    logic        ld_det_en = 0, mc_det_en = 0, ld_irq_en = 0, mc_irq_en = 0;
    logic [1:0]  occ_clr = '0;
    logic [23:0] cur_count;
    logic [31:0] cur_ctrl;
    logic        aux_out, slots_avail, queue_empty, move_done, idle;
    logic        ld_occur, mc_occur, irq;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mvq_sequencer uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cnt_wr(cnt_wr),
        .cnt_wdata(cnt_wdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .step(step), .queue_clr(queue_clr), .ld_det_en(ld_det_en),
        .mc_det_en(mc_det_en), .ld_irq_en(ld_irq_en), .mc_irq_en(mc_irq_en),
        .occ_clr(occ_clr), .cur_count(cur_count), .cur_ctrl(cur_ctrl),
        .aux_out(aux_out), .slots_avail(slots_avail), .queue_empty(queue_empty),
        .move_done(move_done), .idle(idle), .ld_occur(ld_occur),
        .mc_occur(mc_occur), .irq(irq)
    );

    // reference model, built from the requirements
    logic [23:0] m_cq [2];
    logic [31:0] m_kq [2];
    int          m_cn, m_kn;
    logic [23:0] m_cnt;
    logic [31:0] m_ctl;
    logic        m_ld, m_mc, m_mdq;

    function automatic bit exp_done();
        return (m_cnt == 0) && (m_cn == 0);
    endfunction

    function automatic bit exp_irq();
        return (m_ld && ld_irq_en) || (m_mc && mc_irq_en);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cn = 0; m_kn = 0; m_cnt = '0; m_ctl = '0;
            m_ld = 0; m_mc = 0; m_mdq = 1;
        end else begin
            bit ld, pc, pk, md, rise;
            ld   = (m_cnt == 0) && enable && (m_cn > 0) && !queue_clr;   // R2
            md   = exp_done();
            rise = md && !m_mdq;                                          // R8
            m_mdq = md;
            pc   = cnt_wr && (m_cn < 2) && !queue_clr;                    // R1
            pk   = ctl_wr && (m_kn < 2) && !queue_clr;
            if (ld) begin
                m_cnt = m_cq[0]; m_cq[0] = m_cq[1]; m_cn--;
                if (m_kn > 0) begin                                       // R4
                    m_ctl = m_kq[0]; m_kq[0] = m_kq[1]; m_kn--;
                end
            end else if (step && m_cnt != 0) begin                        // R3
                m_cnt = m_cnt - 1;
            end
            if (queue_clr) begin m_cn = 0; m_kn = 0; end                  // R10
            if (pc) begin m_cq[m_cn] = cnt_wdata; m_cn++; end
            if (pk) begin m_kq[m_kn] = ctl_wdata; m_kn++; end
            if (occ_clr[0]) m_ld = 0;
            if (ld && ld_det_en) m_ld = 1;                                // R7
            if (occ_clr[1]) m_mc = 0;
            if (rise && mc_det_en) m_mc = 1;                              // R8
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R2", "cur_count", 32'(cur_count), 32'(m_cnt));
        chk("R4", "cur_ctrl", cur_ctrl, m_ctl);
        chk("R5", "aux_out", 32'(aux_out), 32'(m_ctl[25]));
        chk("R1", "slots_avail", 32'(slots_avail), 32'(m_cn < 2));
        chk("R6", "queue_empty", 32'(queue_empty), 32'(m_cn == 0));
        chk("R6", "move_done", 32'(move_done), 32'(exp_done()));
        chk("R6", "idle", 32'(idle), 32'(exp_done() && m_cn == 0));
        chk("R7", "ld_occur", 32'(ld_occur), 32'(m_ld));
        chk("R8", "mc_occur", 32'(mc_occur), 32'(m_mc));
        chk("R9", "irq", 32'(irq), 32'(exp_irq()));
    endtask

    task automatic quiet();
        cnt_wr = 0; ctl_wr = 0; step = 0; queue_clr = 0; occ_clr = '0;
    endtask

    // wait for the edge, then check at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        void'($urandom(32'h5eed_0b17));
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11: reset state
        chk("R11", "reset cur_count", 32'(cur_count), 32'h0);
        chk("R11", "reset aux_out", 32'(aux_out), 32'h0);
        chk("R11", "reset idle", 32'(idle), 32'h1);
        tick();

        // R1: enable low, three writes; the third is dropped
        ld_det_en = 1; mc_det_en = 1; ld_irq_en = 1; mc_irq_en = 1;
        for (int i = 0; i < 3; i++) begin
            cnt_wr = 1; cnt_wdata = 24'(i + 2);
            ctl_wr = 1; ctl_wdata = (i == 0) ? 32'h0200_0010 : 32'h0000_0020;
            tick();
        end
        quiet();
        tick();
        chk("R1", "full queue keeps slots low", 32'(slots_avail), 32'h0);
        chk("R2", "enable low holds count", 32'(cur_count), 32'h0);

        // R2 and R5: run the queued moves
        enable = 1;
        tick();
        chk("R5", "aux follows first control", 32'(aux_out), 32'h1);
        for (int i = 0; i < 12; i++) begin step = 1; tick(); end
        quiet();
        chk("R6", "drained queue idle", 32'(idle), 32'h1);

        // R10: clear with data queued while a move runs
        cnt_wr = 1; cnt_wdata = 24'd3; tick();
        cnt_wr = 1; cnt_wdata = 24'd4; tick();
        cnt_wr = 0; queue_clr = 1; tick();
        queue_clr = 0;
        chk("R10", "clear keeps current move", 32'(cur_count), 32'd3);
        chk("R10", "clear empties queue", 32'(queue_empty), 32'h1);
        occ_clr = 2'b11; tick(); quiet();

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            enable    = ($urandom_range(9, 0) != 0);
            cnt_wr    = ($urandom_range(4, 0) == 0);
            cnt_wdata = 24'($urandom_range(4, 0));
            ctl_wr    = ($urandom_range(5, 0) == 0);
            ctl_wdata = $urandom();
            step      = $urandom_range(1, 0) == 1;
            queue_clr = ($urandom_range(60, 0) == 0);
            occ_clr   = ($urandom_range(9, 0) == 0) ? 2'($urandom_range(3, 0)) : 2'b00;
            ld_det_en = ($urandom_range(7, 0) != 0);
            mc_det_en = ($urandom_range(7, 0) != 0);
            ld_irq_en = $urandom_range(1, 0) == 1;
            mc_irq_en = $urandom_range(1, 0) == 1;
            tick();
        end
        quiet();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule